// File: doc/BRIEF.md
# Dual-Buffer SPI Read Port

This block is the device side of an SPI link that serves reads out of two on-chip SRAM buffers of 1056 bytes each. A host lowers chip select and sends a one-byte command. The command names one of the two buffers. Three address bytes follow, and only their low 11 bits matter as the start offset. After one padding byte, the block streams bytes from the chosen buffer, most significant bit first, for as long as the host keeps clocking. At the last location it continues from location zero of the same buffer. Raising chip select ends the transfer and releases the output.

All pins are oversampled by a system clock. At each chip-select fall, the block records whether SCK was idle high (mode 3) or idle low (mode 0) and reports this on a pin. In both modes, input bits are taken on SCK rising edges and output bits change on SCK falling edges. A simple synchronous write port fills the buffers before any reads. Commands that are not buffer reads keep the output released until chip select goes high again.

Top module: `dbuf_spi_rd`

## Requirements
- R1: Command byte 8'h54 or 8'hD4 streams from buffer A (write-port select 0).
- R2: Command byte 8'h56 or 8'hD6 streams from buffer B (write-port select 1).
- R3: The start offset is bits [10:0] of the 24-bit address sent MSB first. Bits [23:11] have no effect on the data returned.
- R4: The first data bit appears on `so` at the SCK falling edge that follows the 40th rising edge after chip-select fall (8 command + 24 address + 8 padding bits). Data is sent MSB first and changes only on SCK falling edges.
- R5: After the byte at offset 1055, the stream continues at offset 0 of the same buffer.
- R6: A start offset from 1056 to 2047 is reduced by 1056 before use.
- R7: When chip select rises, `so_oe` goes low within 4 system clocks. This holds even if an SCK falling edge occurs at the same time.
- R8: At every chip-select fall, `cpol_hi` takes the SCK level (1 = mode 3, 0 = mode 0).
- R9: While `rst_n` is low, any transfer is aborted, `so_oe` is 0 and `cpol_hi` is 1.
- R10: After an unrecognised command byte, `so_oe` stays 0 until chip select rises. The next command after that is served normally.
- R11: Reads leave both buffers unchanged, so reading the same region again returns the same bytes.
- R12: `so_oe` is 0 during the command, address and padding bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low reset, sampled on clk |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| si | input | 1 | SPI data from host |
| wr_en | input | 1 | Buffer preload write strobe |
| wr_buf | input | 1 | Preload target: 0 = buffer A, 1 = buffer B |
| wr_addr | input | 11 | Preload byte offset; values of 1056 or more are dropped |
| wr_data | input | 8 | Preload byte |
| so | output | 1 | SPI data to host |
| so_oe | output | 1 | Output enable for `so`; high only while data streams |
| cpol_hi | output | 1 | Detected clock idle level at the last chip-select fall |

## Verification
The chip-select rise and an SCK falling edge can land in the same system clock. One would release the output, and the other would shift out the next data bit. The bench provokes this by lowering SCK and raising chip select in the same cycle in the middle of a data byte. Both inputs pass through synchronisers of equal depth, so the two events reach the engine together. The bench then requires `so_oe` to be low a few clocks later, and requires the next command to return the correct bytes from a fresh start offset.

// File: rtl/dbuf_spi_pkg.sv
package dbuf_spi_pkg;

    localparam int unsigned BUF_DEPTH_DEF = 1056;
    localparam int unsigned CMD_BITS      = 8;
    localparam int unsigned ADDR_BITS     = 24;
    localparam int unsigned PAD_BITS      = 8;

    localparam logic [7:0] OPC_A_STD = 8'h54;
    localparam logic [7:0] OPC_A_ALT = 8'hD4;
    localparam logic [7:0] OPC_B_STD = 8'h56;
    localparam logic [7:0] OPC_B_ALT = 8'hD6;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADDR,
        PH_PAD,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef enum logic {
        BUF_A = 1'b0,
        BUF_B = 1'b1
    } buf_sel_e;

    typedef struct packed {
        logic     valid;
        buf_sel_e sel;
    } opc_dec_t;

    // synchronised pin levels and single-cycle edge events
    typedef struct packed {
        logic lvl_cs_n;
        logic lvl_sck;
        logic lvl_si;
        logic cs_fall;
        logic cs_rise;
        logic sck_rise;
        logic sck_fall;
    } pin_evt_t;

    function automatic opc_dec_t decode_opc(input logic [7:0] op);
        opc_dec_t d;
        d.valid = 1'b1;
        d.sel   = BUF_A;
        case (op)
            OPC_A_STD, OPC_A_ALT: d.sel = BUF_A;
            OPC_B_STD, OPC_B_ALT: d.sel = BUF_B;
            default:              d.valid = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dbuf_pin_sync.sv
module dbuf_pin_sync
    import dbuf_spi_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  logic     sck,
    input  logic     si,
    output pin_evt_t evt
);

    logic [STAGES-1:0] cs_pipe;
    logic [STAGES-1:0] sck_pipe;
    logic [STAGES-1:0] si_pipe;
    logic              cs_q;
    logic              sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_pipe  <= '1;
            sck_pipe <= '1;
            si_pipe  <= '0;
            cs_q     <= 1'b1;
            sck_q    <= 1'b1;
        end else begin
            cs_pipe  <= {cs_pipe[STAGES-2:0], cs_n};
            sck_pipe <= {sck_pipe[STAGES-2:0], sck};
            si_pipe  <= {si_pipe[STAGES-2:0], si};
            cs_q     <= cs_pipe[STAGES-1];
            sck_q    <= sck_pipe[STAGES-1];
        end
    end

    always_comb begin
        evt.lvl_cs_n = cs_pipe[STAGES-1];
        evt.lvl_sck  = sck_pipe[STAGES-1];
        evt.lvl_si   = si_pipe[STAGES-1];
        evt.cs_fall  = cs_q & ~cs_pipe[STAGES-1];
        evt.cs_rise  = ~cs_q & cs_pipe[STAGES-1];
        evt.sck_rise = ~sck_q & sck_pipe[STAGES-1] & ~cs_pipe[STAGES-1];
        evt.sck_fall = sck_q & ~sck_pipe[STAGES-1] & ~cs_pipe[STAGES-1];
    end

endmodule

// File: rtl/dbuf_store.sv
module dbuf_store
    import dbuf_spi_pkg::*;
#(
    parameter int unsigned DEPTH = BUF_DEPTH_DEF,
    parameter int unsigned OFS_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             wr_buf,
    input  logic [OFS_W-1:0] wr_addr,
    input  logic [7:0]       wr_data,
    input  buf_sel_e         rd_sel,
    input  logic [OFS_W-1:0] rd_ptr,
    output logic [7:0]       rd_byte
);

    localparam int unsigned NBUF    = 2;
    localparam logic [OFS_W:0] DEPTH_V = (OFS_W+1)'(DEPTH);

    logic [7:0] bank_q [NBUF];
    logic       in_range;

    assign in_range = ({1'b0, wr_addr} < DEPTH_V);

    for (genvar g = 0; g < NBUF; g++) begin : g_bank
        logic [7:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && in_range && (wr_buf == g[0])) begin
                mem[wr_addr] <= wr_data;
            end
        end

        assign bank_q[g] = mem[rd_ptr];
    end

    assign rd_byte = bank_q[rd_sel];

endmodule

// File: rtl/dbuf_cmd_fsm.sv
module dbuf_cmd_fsm
    import dbuf_spi_pkg::*;
#(
    parameter int unsigned DEPTH = BUF_DEPTH_DEF,
    parameter int unsigned OFS_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  pin_evt_t         evt,
    input  logic [7:0]       rd_byte,
    output phase_e           ph,
    output buf_sel_e         rd_sel,
    output logic [OFS_W-1:0] rd_ptr,
    output logic [2:0]       bit_pos,
    output logic             so,
    output logic             so_oe,
    output logic             cpol_hi
);

    localparam int unsigned SH_W  = ((OFS_W > CMD_BITS) ? OFS_W : CMD_BITS) - 1;
    localparam int unsigned CNT_W = $clog2(ADDR_BITS);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BITS - 1);
    localparam logic [CNT_W-1:0] PAD_LAST  = CNT_W'(PAD_BITS - 1);
    localparam logic [OFS_W:0]   DEPTH_V   = (OFS_W+1)'(DEPTH);
    localparam logic [OFS_W-1:0] LAST_OFS  = OFS_W'(DEPTH - 1);

    logic [SH_W-1:0]  sh;
    logic [CNT_W-1:0] cnt;
    opc_dec_t         dec;
    logic [OFS_W-1:0] raw_ofs;

    // a raw offset is below 2*DEPTH because OFS_W = clog2(DEPTH)
    function automatic logic [OFS_W-1:0] fold_ofs(input logic [OFS_W-1:0] raw);
        logic [OFS_W:0] wide;
        wide = {1'b0, raw};
        if (wide >= DEPTH_V) begin
            wide = wide - DEPTH_V;
        end
        return wide[OFS_W-1:0];
    endfunction

    function automatic logic [OFS_W-1:0] next_ofs(input logic [OFS_W-1:0] cur);
        return (cur == LAST_OFS) ? '0 : cur + 1'b1;
    endfunction

    assign dec     = decode_opc({sh[CMD_BITS-2:0], evt.lvl_si});
    assign raw_ofs = {sh[OFS_W-2:0], evt.lvl_si};

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            cnt     <= '0;
            sh      <= '0;
            rd_sel  <= BUF_A;
            rd_ptr  <= '0;
            bit_pos <= '0;
            so      <= 1'b0;
            so_oe   <= 1'b0;
            cpol_hi <= 1'b1;
        end else if (evt.cs_rise) begin
            ph    <= PH_IDLE;
            so_oe <= 1'b0;
        end else if (evt.cs_fall) begin
            ph      <= PH_OPC;
            cnt     <= '0;
            so_oe   <= 1'b0;
            cpol_hi <= evt.lvl_sck;
        end else if (!evt.lvl_cs_n) begin
            unique case (ph)
                PH_OPC: begin
                    if (evt.sck_rise) begin
                        sh <= {sh[SH_W-2:0], evt.lvl_si};
                        if (cnt == CMD_LAST) begin
                            cnt <= '0;
                            if (dec.valid) begin
                                ph     <= PH_ADDR;
                                rd_sel <= dec.sel;
                            end else begin
                                ph <= PH_SKIP;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_ADDR: begin
                    if (evt.sck_rise) begin
                        sh <= {sh[SH_W-2:0], evt.lvl_si};
                        if (cnt == ADDR_LAST) begin
                            cnt    <= '0;
                            rd_ptr <= fold_ofs(raw_ofs);
                            ph     <= PH_PAD;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_PAD: begin
                    if (evt.sck_rise) begin
                        if (cnt == PAD_LAST) begin
                            cnt     <= '0;
                            bit_pos <= '0;
                            ph      <= PH_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_DATA: begin
                    if (evt.sck_fall) begin
                        so      <= rd_byte[3'd7 - bit_pos];
                        so_oe   <= 1'b1;
                        bit_pos <= bit_pos + 1'b1;
                        if (bit_pos == 3'd7) begin
                            rd_ptr <= next_ofs(rd_ptr);
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/dbuf_spi_rd.sv
module dbuf_spi_rd
    import dbuf_spi_pkg::*;
#(
    parameter int unsigned BUF_DEPTH   = BUF_DEPTH_DEF,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned OFS_W       = $clog2(BUF_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck,
    input  logic             si,
    input  logic             wr_en,
    input  logic             wr_buf,
    input  logic [OFS_W-1:0] wr_addr,
    input  logic [7:0]       wr_data,
    output logic             so,
    output logic             so_oe,
    output logic             cpol_hi
);

    logic             rst;
    pin_evt_t         evt;
    phase_e           ph;
    buf_sel_e         rd_sel;
    logic [OFS_W-1:0] rd_ptr;
    logic [2:0]       bit_pos;
    logic [7:0]       rd_byte;

    assign rst = ~rst_n;

    dbuf_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sck  (sck),
        .si   (si),
        .evt  (evt)
    );

    dbuf_store #(
        .DEPTH (BUF_DEPTH),
        .OFS_W (OFS_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_buf  (wr_buf),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_ptr  (rd_ptr),
        .rd_byte (rd_byte)
    );

    dbuf_cmd_fsm #(
        .DEPTH (BUF_DEPTH),
        .OFS_W (OFS_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .rd_byte (rd_byte),
        .ph      (ph),
        .rd_sel  (rd_sel),
        .rd_ptr  (rd_ptr),
        .bit_pos (bit_pos),
        .so      (so),
        .so_oe   (so_oe),
        .cpol_hi (cpol_hi)
    );

endmodule

// File: rtl/dbuf_spi_rd_chk.sv
module dbuf_spi_rd_chk
    import dbuf_spi_pkg::*;
#(
    parameter int unsigned DEPTH = BUF_DEPTH_DEF,
    parameter int unsigned OFS_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input pin_evt_t         evt,
    input phase_e           ph,
    input logic [OFS_W-1:0] rd_ptr,
    input logic [2:0]       bit_pos,
    input logic             so,
    input logic             so_oe,
    input logic             cpol_hi
);

    logic rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
    end

    always @(posedge clk) begin
        if (rst_d) begin
            AST_RESET_IDLE: assert (!so_oe && cpol_hi); // R9
        end
    end

    AST_CSRISE_RELEASE: assert property (@(posedge clk) disable iff (rst) evt.cs_rise |=> !so_oe); // R7
    AST_MODE_CAPTURE: assert property (@(posedge clk) disable iff (rst) evt.cs_fall |=> (cpol_hi == $past(evt.lvl_sck))); // R8
    AST_OE_DATA_ONLY: assert property (@(posedge clk) disable iff (rst) so_oe |-> (ph == PH_DATA)); // R12
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst) (ph == PH_SKIP) |-> !so_oe); // R10
    AST_PTR_IN_BUF: assert property (@(posedge clk) disable iff (rst) int'(rd_ptr) < DEPTH); // R6
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (evt.sck_fall && !evt.cs_rise && !evt.cs_fall && !evt.lvl_cs_n && (ph == PH_DATA)
         && (bit_pos == 3'd7) && (int'(rd_ptr) == DEPTH - 1)) |=> (rd_ptr == '0)); // R5
    AST_SO_ON_FALL: assert property (@(posedge clk) disable iff (rst) !evt.sck_fall |=> $stable(so)); // R4

endmodule

bind dbuf_spi_rd dbuf_spi_rd_chk #(
    .DEPTH (BUF_DEPTH),
    .OFS_W (OFS_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt),
    .ph      (ph),
    .rd_ptr  (rd_ptr),
    .bit_pos (bit_pos),
    .so      (so),
    .so_oe   (so_oe),
    .cpol_hi (cpol_hi)
);

// File: tb/dbuf_spi_rd_bench.sv
module dbuf_spi_rd_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int DEPTH      = 1056;
    localparam int WD_CYCLES  = 200000;

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b1;
    logic        si = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_buf = 1'b0;
    logic [10:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        so;
    logic        so_oe;
    logic        cpol_hi;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] mdl [2][DEPTH];
    exp_t       exp_q [$];
    logic [7:0] got_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbuf_spi_rd u_dbuf_spi_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sck     (sck),
        .si      (si),
        .wr_en   (wr_en),
        .wr_buf  (wr_buf),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .so      (so),
        .so_oe   (so_oe),
        .cpol_hi (cpol_hi)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expected items as received bytes arrive
    initial begin
        exp_t e;
        logic [7:0] g;
        forever begin
            @(negedge clk);
            while (got_q.size() > 0) begin
                g = got_q.pop_front();
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1 scoreboard underflow", int'(g), 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(g == e.val, e.req, int'(g), int'(e.val));
                end
            end
        end
    end

    initial begin
        wait_clk(WD_CYCLES);
        n_bad++;
        $display("FAIL watchdog act=%0d exp=%0d", WD_CYCLES, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output bit oe_hi, output bit oe_lo);
        oe_hi = 1'b0;
        oe_lo = 1'b0;
        rx = '0;
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0;
            si  = tx[i];
            wait_clk(HALF);
            rx[i] = so;
            if (so_oe) oe_hi = 1'b1; else oe_lo = 1'b1;
            sck = 1'b1;
            wait_clk(HALF);
        end
    endtask

    task automatic spi_begin(input bit m3);
        sck = m3;
        wait_clk(4);
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic spi_end(input bit m3);
        if (!m3) begin
            sck = 1'b0;
            wait_clk(HALF);
        end
        cs_n = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic send_header(input logic [7:0] op, input logic [23:0] addr, output bit any_hi);
        logic [7:0] rx;
        bit hi, lo;
        any_hi = 1'b0;
        xfer(op, rx, hi, lo);           any_hi |= hi;
        xfer(addr[23:16], rx, hi, lo);  any_hi |= hi;
        xfer(addr[15:8], rx, hi, lo);   any_hi |= hi;
        xfer(addr[7:0], rx, hi, lo);    any_hi |= hi;
        xfer(8'hA5, rx, hi, lo);        any_hi |= hi;
    endtask

    task automatic read_cmd(input logic [7:0] op, input logic [23:0] addr, input int n, input bit m3,
                            input int bsel, input int start, input string req);
        logic [7:0] rx;
        bit hi, lo, hdr_hi, any_lo;
        exp_t e;
        spi_begin(m3);
        chk(cpol_hi == m3, "R8 mode capture", int'(cpol_hi), int'(m3));
        send_header(op, addr, hdr_hi);
        chk(!hdr_hi, "R12 so_oe low in header", int'(hdr_hi), 0);
        any_lo = 1'b0;
        for (int k = 0; k < n; k++) begin
            e.val = mdl[bsel][(start + k) % DEPTH];
            e.req = req;
            exp_q.push_back(e);
            xfer(8'h00, rx, hi, lo);
            any_lo |= lo;
            got_q.push_back(rx);
        end
        chk(!any_lo, "R4 so_oe high in data", int'(any_lo), 0);
        spi_end(m3);
        chk(!so_oe, "R7 released after cs rise", int'(so_oe), 0);
    endtask

    initial begin
        logic [7:0] rx;
        bit hi, lo, hdr_hi, any_hi;
        for (int i = 0; i < DEPTH; i++) begin
            mdl[0][i] = 8'(i * 7 + 3);
            mdl[1][i] = ~8'(i * 13 + 5);
        end
        wait_clk(5);
        chk(!so_oe, "R9 reset so_oe", int'(so_oe), 0);
        chk(cpol_hi, "R9 reset cpol_hi", int'(cpol_hi), 1);
        rst_n = 1'b1;
        wait_clk(3);

        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < DEPTH; i++) begin
                wr_en = 1'b1; wr_buf = b[0]; wr_addr = 11'(i); wr_data = mdl[b][i];
                wait_clk(1);
            end
        end
        wr_en = 1'b0;
        wait_clk(2);

        read_cmd(8'h54, 24'h000010, 6, 1'b0, 0, 16, "R1 opcode 54");
        read_cmd(8'hD4, 24'h000200, 4, 1'b1, 0, 512, "R1 opcode D4");
        read_cmd(8'h56, 24'h000033, 5, 1'b1, 1, 51, "R2 opcode 56");
        read_cmd(8'hD6, 24'h000100, 4, 1'b0, 1, 256, "R2 opcode D6");
        read_cmd(8'h54, 24'hFFF820, 4, 1'b1, 0, 32, "R3 upper bits ignored");
        read_cmd(8'h56, 24'h00041D, 6, 1'b0, 1, 1053, "R5 wrap to zero");
        read_cmd(8'h54, 24'h0007FF, 3, 1'b1, 0, 991, "R6 offset 2047 folded");
        read_cmd(8'hD6, 24'h000420, 3, 1'b1, 1, 0, "R6 offset 1056 folded");

        // R10: unknown opcode keeps output released
        spi_begin(1'b1);
        send_header(8'h53, 24'h000010, hdr_hi);
        any_hi = hdr_hi;
        for (int k = 0; k < 3; k++) begin
            xfer(8'h00, rx, hi, lo);
            any_hi |= hi;
        end
        chk(!any_hi, "R10 unknown opcode silent", int'(any_hi), 0);
        spi_end(1'b1);
        read_cmd(8'h56, 24'h000007, 3, 1'b0, 1, 7, "R10 recovery read");

        // R7: cs rise coincides with an SCK falling edge mid-byte
        spi_begin(1'b1);
        send_header(8'hD4, 24'h000040, hdr_hi);
        xfer(8'h00, rx, hi, lo);
        sck = 1'b0; si = 1'b0; wait_clk(HALF);
        sck = 1'b1; wait_clk(HALF);
        @(negedge clk);
        sck = 1'b0;
        cs_n = 1'b1;
        wait_clk(4);
        chk(!so_oe, "R7 cs rise with sck fall", int'(so_oe), 0);
        sck = 1'b1;
        wait_clk(HALF);
        read_cmd(8'h54, 24'h000041, 2, 1'b1, 0, 65, "R7 fresh start after collision");

        // R9: reset aborts a running read
        spi_begin(1'b0);
        send_header(8'h56, 24'h000090, hdr_hi);
        xfer(8'h00, rx, hi, lo);
        rst_n = 1'b0;
        wait_clk(3);
        chk(!so_oe, "R9 abort so_oe", int'(so_oe), 0);
        chk(cpol_hi, "R9 abort cpol_hi", int'(cpol_hi), 1);
        cs_n = 1'b1; sck = 1'b1;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        read_cmd(8'hD6, 24'h000090, 3, 1'b1, 1, 144, "R9 read after reset");

        // R11: repeat earlier regions, contents unchanged
        read_cmd(8'h54, 24'h000010, 6, 1'b1, 0, 16, "R11 reread buffer A");
        read_cmd(8'h56, 24'h00041D, 6, 1'b1, 1, 1053, "R11 reread buffer B");

        wait_clk(10);
        chk(exp_q.size() == 0, "R4 all expected bytes seen", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule